// File: doc/BRIEF.md
# NAND Attribute-Space Access Timing Sequencer

This block produces the pin-level strobe timing for a single read or write to the attribute memory space of a NAND flash device. A host issues one request, made of a read/write flag, an address and write data. The sequencer then drives the device address. After a programmable lead time it lowers the write strobe or the read strobe. It keeps that strobe low for a programmable minimum, and longer while the device holds its wait line low. It then keeps the address (and, on writes, the data) steady for a programmable trailing time. At the end it pulses `done` for one cycle.

A 32-bit timing register holds four 8-bit counts: lead, strobe, trail and bus float. On writes, the float count keeps the data bus undriven for a number of cycles counted from the start of the access. Reads never drive the bus. The read data is captured on the edge where the read strobe rises. The block takes the register fields when it accepts a request, so rewriting the register during an access only affects later accesses. The device wait line passes through a two-flop synchronizer before the sequencer uses it.

Top module: `nand_attr_seq`

## Requirements
- R1: After reset, `cfg_rdata` reads 0xFCFCFCFC, `busy` and `done` are 0, both strobes are high and `dev_data_oe` is 0. The register fields are lead [7:0], strobe [15:8], trail [23:16] and float [31:24]. A write with `cfg_we` high updates the register at the next edge.
- R2: A request is accepted on an edge where `req_valid` is 1 and `busy` is 0. `busy` rises and `dev_addr` shows `req_addr` in the cycle after that edge, which is cycle 0 of the access. The strobe goes low in cycle lead+1, so the address is set up for lead+1 cycles. The strobe is `dev_we_n` for a write (`req_write`=1) and `dev_re_n` for a read. The other strobe stays high.
- R3: Once low, the strobe stays low for at least strobe+1 cycles.
- R4: `dev_wait_n` is sampled through two flops, so its value at edge k is used at edge k+2. At the end of the minimum strobe time, and at every later edge, the strobe is released only if the synchronized wait value is 1. Otherwise the strobe stays low.
- R5: After the strobe rises, the access lasts exactly trail more cycles with `dev_addr` unchanged. `done` is 1 for one cycle in the first cycle after that, and `busy` is 0 in that same cycle. With trail=0, `done` appears in the cycle where the strobe rises.
- R6: On a write, `dev_data_oe` is 0 for the first float cycles of the access (cycles 0 to float-1). It is 1 from cycle float until the access ends, with `dev_wdata` equal to the accepted `req_wdata`. If float is at least the access length, the bus is never driven.
- R7: A read never raises `dev_data_oe`. `rd_data` takes `dev_rdata` as sampled at the edge where `dev_re_n` rises, and holds it until the next read.
- R8: The four counts are taken from the register at the accepting edge. A register write during an access does not change that access's timing.
- R9: `req_valid` is ignored while `busy` is 1. A request presented in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing register write enable |
| cfg_wdata | input | 32 | Timing register write value |
| cfg_rdata | output | 32 | Timing register contents |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | DATA_W | Captured read data |
| dev_addr | output | ADDR_W | Device address |
| dev_we_n | output | 1 | Active-low write strobe |
| dev_re_n | output | 1 | Active-low read strobe |
| dev_wdata | output | DATA_W | Device write data |
| dev_data_oe | output | 1 | Data bus output enable |
| dev_rdata | input | DATA_W | Device read data |
| dev_wait_n | input | 1 | Active-low device wait |

## Verification
A wrong phase count or a wrong phase transition shows within one cycle as a strobe edge in the wrong cycle, because every strobe and enable is a registered output compared against the model on every clock. A mis-latched field or a lost float count shows up either as a strobe window of the wrong length or as `dev_data_oe` rising in the wrong cycle. A synchronizer of the wrong depth moves the release under wait by exactly one edge. A captured-data fault shows on `rd_data` in the `done` cycle of the read. The register-write and request events during an access test that the latched fields and the accepted request cannot be disturbed while `busy` is high.

// File: rtl/nand_attr_pkg.sv
package nand_attr_pkg;
  localparam int FIELD_W = 8;
  localparam int CFG_W   = 4 * FIELD_W;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'hFCFC_FCFC;

  // Field order matches register bit positions (MSB first).
  typedef struct packed {
    logic [FIELD_W-1:0] hiz;     // [31:24] bus float count, writes only
    logic [FIELD_W-1:0] trail;   // [23:16] hold after strobe release
    logic [FIELD_W-1:0] strobe;  // [15:8]  minimum strobe length - 1
    logic [FIELD_W-1:0] lead;    // [7:0]   address setup - 1
  } timing_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_CMD   = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;
endpackage

// File: rtl/nand_attr_cfg_reg.sv
module nand_attr_cfg_reg #(
  parameter int          W         = 32,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RESET_VAL;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/nand_attr_sync.sv
module nand_attr_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RESET_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RESET_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nand_attr_fsm.sv
module nand_attr_fsm
  import nand_attr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  timing_t           timing,
  input  logic              wait_ok,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dev_we_n,
  output logic              dev_re_n,
  output logic              busy,
  output logic              done,
  output logic              is_write,
  output logic              accept,
  output logic              release_p,
  output logic              finish
);
  phase_e             phase;
  logic [FIELD_W-1:0] cnt;
  logic [FIELD_W-1:0] strobe_q;
  logic [FIELD_W-1:0] trail_q;
  logic               cnt_zero;

  assign cnt_zero  = (cnt == '0);
  assign accept    = (phase == PH_IDLE) && req_valid;
  assign release_p = (phase == PH_CMD) && cnt_zero && wait_ok;
  assign finish    = (release_p && (trail_q == '0)) ||
                     ((phase == PH_HOLD) && cnt_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      strobe_q <= '0;
      trail_q  <= '0;
      dev_addr <= '0;
      dev_we_n <= 1'b1;
      dev_re_n <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      is_write <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase    <= PH_SETUP;
            cnt      <= timing.lead;
            strobe_q <= timing.strobe;
            trail_q  <= timing.trail;
            dev_addr <= req_addr;
            is_write <= req_write;
            busy     <= 1'b1;
          end
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            phase <= PH_CMD;
            cnt   <= strobe_q;
            if (is_write) dev_we_n <= 1'b0;
            else          dev_re_n <= 1'b0;
          end else begin
            cnt <= cnt - FIELD_W'(1);
          end
        end
        PH_CMD: begin
          if (!cnt_zero) begin
            cnt <= cnt - FIELD_W'(1);
          end else if (wait_ok) begin
            dev_we_n <= 1'b1;
            dev_re_n <= 1'b1;
            if (!finish) begin
              phase <= PH_HOLD;
              cnt   <= trail_q - FIELD_W'(1);
            end
          end
        end
        PH_HOLD: begin
          if (!cnt_zero) cnt <= cnt - FIELD_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
      if (finish) begin
        phase <= PH_IDLE;
        busy  <= 1'b0;
        done  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_attr_bus.sv
module nand_attr_bus
  import nand_attr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [FIELD_W-1:0] hiz,
  input  logic               busy,
  input  logic               is_write,
  input  logic               release_p,
  input  logic               finish,
  input  logic [DATA_W-1:0]  dev_rdata,
  output logic [DATA_W-1:0]  dev_wdata,
  output logic               dev_data_oe,
  output logic [DATA_W-1:0]  rd_data
);
  logic [FIELD_W-1:0] float_cnt;
  logic               floating;

  assign floating = busy && is_write && !dev_data_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_wdata   <= '0;
      dev_data_oe <= 1'b0;
      float_cnt   <= '0;
      rd_data     <= '0;
    end else begin
      if (accept) begin
        dev_wdata   <= req_wdata;
        dev_data_oe <= req_write && (hiz == '0);
        float_cnt   <= (hiz == '0) ? '0 : hiz - FIELD_W'(1);
      end else if (finish) begin
        dev_data_oe <= 1'b0;
      end else if (floating) begin
        if (float_cnt == '0) dev_data_oe <= 1'b1;
        else                 float_cnt   <= float_cnt - FIELD_W'(1);
      end
      if (release_p && !is_write) rd_data <= dev_rdata;
    end
  end
endmodule

// File: rtl/nand_attr_seq.sv
module nand_attr_seq
  import nand_attr_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dev_we_n,
  output logic              dev_re_n,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              dev_data_oe,
  input  logic [DATA_W-1:0] dev_rdata,
  input  logic              dev_wait_n
);
  timing_t cfg_q;
  logic    wait_ok;
  logic    is_write, accept, release_p, finish;

  nand_attr_cfg_reg #(.W(CFG_W), .RESET_VAL(CFG_RESET)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
  );
  assign cfg_rdata = cfg_q;

  nand_attr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
    .clk(clk), .rst(rst), .d(dev_wait_n), .q(wait_ok)
  );

  nand_attr_fsm #(.ADDR_W(ADDR_W)) fsm_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .timing(cfg_q), .wait_ok(wait_ok),
    .dev_addr(dev_addr), .dev_we_n(dev_we_n), .dev_re_n(dev_re_n),
    .busy(busy), .done(done), .is_write(is_write),
    .accept(accept), .release_p(release_p), .finish(finish)
  );

  nand_attr_bus #(.DATA_W(DATA_W)) bus_i (
    .clk(clk), .rst(rst),
    .accept(accept), .req_write(req_write), .req_wdata(req_wdata),
    .hiz(cfg_q.hiz), .busy(busy), .is_write(is_write),
    .release_p(release_p), .finish(finish),
    .dev_rdata(dev_rdata), .dev_wdata(dev_wdata),
    .dev_data_oe(dev_data_oe), .rd_data(rd_data)
  );
endmodule

// File: rtl/nand_attr_chk.sv
module nand_attr_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              dev_we_n,
  input logic              dev_re_n,
  input logic              dev_data_oe,
  input logic [ADDR_W-1:0] dev_addr
);
  // R2: never both strobes low
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!dev_we_n && !dev_re_n));
  // R2: strobes only inside an access
  a_r2_strobe_in_access: assert property (@(posedge clk) disable iff (rst)
    (!dev_we_n || !dev_re_n) |-> busy);
  // R7: read strobe never coexists with a driven bus
  a_r7_read_no_drive: assert property (@(posedge clk) disable iff (rst)
    !dev_re_n |-> !dev_data_oe);
  // R6: bus driven only while busy
  a_r6_oe_in_access: assert property (@(posedge clk) disable iff (rst)
    dev_data_oe |-> busy);
  // R5: done lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5: end of busy is marked by done
  a_r5_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R9: address steady across an access
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(dev_addr));
endmodule

bind nand_attr_seq nand_attr_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .dev_we_n(dev_we_n), .dev_re_n(dev_re_n),
  .dev_data_oe(dev_data_oe), .dev_addr(dev_addr)
);

// File: tb/nand_attr_seq_tb_top.sv
module nand_attr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          busy, done;
  logic [DW-1:0] rd_data, dev_wdata, dev_rdata = '0;
  logic [AW-1:0] dev_addr;
  logic          dev_we_n, dev_re_n, dev_data_oe;
  logic          dev_wait_n = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_attr_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .dev_addr(dev_addr), .dev_we_n(dev_we_n),
    .dev_re_n(dev_re_n), .dev_wdata(dev_wdata), .dev_data_oe(dev_data_oe),
    .dev_rdata(dev_rdata), .dev_wait_n(dev_wait_n)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  int      n = 0;           // edges so far
  int      whist[$];        // dev_wait_n value seen at each edge
  logic [31:0] m_cfg = 32'hFCFC_FCFC;
  bit      m_busy = 0, m_done = 0, m_wr = 0;
  int      m_e = 0, m_s = 0, m_w = 0, m_h = 0, m_z = 0, m_rel = -1;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0, m_rd = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual %h expected %h", req, what, n, act, exp);
    end
  endtask

  function automatic bit wsync(input int k);
    return (k >= 2) ? bit'(whist[k-2]) : 1'b1;
  endfunction

  task automatic model_edge();
    bit was_busy = m_busy;
    m_done = 0;
    if (rst) begin
      m_busy = 0; m_cfg = 32'hFCFC_FCFC; m_rd = '0;
      return;
    end
    if (!was_busy && req_valid) begin
      m_busy = 1; m_e = 0; m_rel = -1; m_wr = req_write;
      m_addr = req_addr; m_wd = req_wdata;
      m_s = m_cfg[7:0]; m_w = m_cfg[15:8]; m_h = m_cfg[23:16]; m_z = m_cfg[31:24];
    end else if (was_busy) begin
      m_e++;
      if (m_rel < 0 && m_e >= m_s + m_w + 2 && wsync(n)) begin
        m_rel = m_e;
        if (!m_wr) m_rd = dev_rdata;
      end
      if (m_rel >= 0 && m_e == m_rel + m_h) begin
        m_busy = 0; m_done = 1;
      end
    end
    if (cfg_we) m_cfg = cfg_wdata;
  endtask

  task automatic compare();
    bit strobe_low = m_busy && (m_e >= m_s + 1) && (m_rel < 0 || m_e < m_rel);
    bit exp_oe = m_busy && m_wr && (m_e >= m_z);
    chk(cfg_rdata == m_cfg, "R1", "cfg_rdata", cfg_rdata, m_cfg);
    chk(busy == m_busy, "R2 R9", "busy", 32'(busy), 32'(m_busy));
    chk(done == m_done, "R5", "done", 32'(done), 32'(m_done));
    chk(dev_we_n == !(strobe_low && m_wr), "R2 R3 R4", "dev_we_n",
        32'(dev_we_n), 32'(!(strobe_low && m_wr)));
    chk(dev_re_n == !(strobe_low && !m_wr), "R2 R3 R4", "dev_re_n",
        32'(dev_re_n), 32'(!(strobe_low && !m_wr)));
    chk(dev_data_oe == exp_oe, "R6 R7", "dev_data_oe", 32'(dev_data_oe), 32'(exp_oe));
    if (m_busy) chk(dev_addr == m_addr, "R5 R9", "dev_addr", 32'(dev_addr), 32'(m_addr));
    if (exp_oe) chk(dev_wdata == m_wd, "R6", "dev_wdata", 32'(dev_wdata), 32'(m_wd));
    if (!rst) chk(rd_data == m_rd, "R7", "rd_data", 32'(rd_data), 32'(m_rd));
  endtask

  task automatic tick();
    whist.push_back(int'(dev_wait_n));
    @(posedge clk);
    model_edge();
    n++;
    @(negedge clk);
    compare();
    dev_rdata = DW'(16'hA500 + n);
  endtask

  task automatic do_access(input bit wr, input logic [AW-1:0] addr,
                           input logic [DW-1:0] wd, input bit set_cfg,
                           input logic [31:0] cfg, input int wl_lo, input int wl_hi,
                           input bit mid_cfg, input bit mid_req);
    int a0;
    int guard = 0;
    if (set_cfg) begin
      cfg_we = 1; cfg_wdata = cfg; tick(); cfg_we = 0;
    end
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd;
    a0 = n;
    tick();
    req_valid = 0;
    while (m_busy && guard < 4000) begin
      dev_wait_n = 1'b1;
      if (wl_lo >= 0 && (n - a0) >= wl_lo && (n - a0) < wl_hi) dev_wait_n = 1'b0;
      if (mid_req && m_e == 1) begin
        req_valid = 1; req_write = !wr; req_addr = ~addr; req_wdata = ~wd;
      end
      if (mid_cfg && m_e == 2) begin
        cfg_we = 1; cfg_wdata = 32'h0505_0505;
      end
      tick();
      req_valid = 0; cfg_we = 0;
      guard++;
    end
    dev_wait_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    repeat (4) tick();                 // R1 reset state
    rst = 0;
    repeat (2) tick();
    // R1 R8: reset-valued fields (252 each) drive a full write
    do_access(1, 16'h1234, 16'hBEEF, 0, 32'h0, -1, -1, 0, 0);
    // R2 R7: all-zero timing read, trail=0 done at release
    do_access(0, 16'h0042, 16'h0, 1, 32'h0000_0000, -1, -1, 0, 0);
    // R2 R3 R5 R6: write lead=2 strobe=1 trail=2 float=3
    do_access(1, 16'h0F0F, 16'h5A5A, 1, 32'h0302_0102, -1, -1, 0, 0);
    // R4 R7: read with wait held low across the release point
    do_access(0, 16'h7001, 16'h0, 1, 32'h0003_0204, 5, 14, 0, 0);
    // R4: wait low pulse ending exactly at the minimum
    do_access(0, 16'h7002, 16'h0, 0, 32'h0, 3, 8, 0, 0);
    // R8 R9: register rewrite and extra request mid-access
    do_access(1, 16'h3C3C, 16'hC3C3, 1, 32'h0101_0101, -1, -1, 1, 1);
    // R6: float longer than the access, bus never driven
    do_access(1, 16'h0101, 16'h1111, 1, 32'h4000_0000, -1, -1, 0, 0);
    // R9: request accepted in the done cycle
    do_access(0, 16'h0202, 16'h0, 0, 32'h0, -1, -1, 0, 0);
    do_access(1, 16'h0303, 16'h3333, 0, 32'h0, -1, -1, 0, 0);
    repeat (3) tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule